// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 9-bit first-in first-out buffer. The producer side and the consumer side run on independent clocks. A write port with two enables stores words on the write clock. A read port with two enables and an output enable returns them on the read clock, in the order they were written. Four active-low status flags report the fill level. Empty and full are exact bounds. Almost-empty and almost-full trip at thresholds that software can load.

One write-side control pin has two roles, and its level while reset is held decides which one applies. If the pin is high at reset, it acts as a second write enable. If it is low at reset, the block is in offset-load mode. In that mode, driving the pin low together with write enable 1 sends each write-clock edge to the threshold registers instead of the storage array. The registers are loaded in a fixed four-step order that wraps. The producer and consumer pointers cross between the two clock domains in Gray code. Full and almost-full are computed on the write side. Empty and almost-empty are computed on the read side.

Top module: `fifo_dualclk`

## Requirements
- R1: Words of 9 bits are returned on `rdata` unchanged and in the order they were written.
- R2: A word is stored on a rising `wclk` edge only when `wr_en1_n` is low, `wr_en2_ld` is high and `full_n` is high. With `wr_en2_ld` low, nothing enters the array in either mode.
- R3: While `full_n` is low, write attempts store nothing and the fill level stays at DEPTH.
- R4: A word is consumed on a rising `rclk` edge only when `rd_en1_n` and `rd_en2_n` are both low and `empty_n` is high. If either enable is high, no word is consumed.
- R5: A read attempt while `empty_n` is low is ignored. The next word written is the next word read.
- R6: The level of `wr_en2_ld` while `rst_n` is low selects the mode. High selects second-enable mode, and in that mode a low level never loads the thresholds. Low selects offset-load mode.
- R7: In offset-load mode, an edge with `wr_en1_n` low and `wr_en2_ld` low writes no array word. It loads `wdata[7:0]` into one threshold byte, in this cycle: almost-empty bits 7:0, almost-empty bits 15:8, almost-full bits 7:0, almost-full bits 15:8, then back to the first step. The cycle restarts at the first step after each reset.
- R8: After reset, both thresholds are 7.
- R9: `empty_n` is low exactly when the settled fill level is 0. `full_n` is low exactly when it equals DEPTH.
- R10: `almost_empty_n` is low when the fill level is at most the almost-empty threshold. `almost_full_n` is low when the fill level plus the almost-full threshold is at least DEPTH.
- R11: `rdata` is high-impedance while `out_en_n` is high. Otherwise it shows the last word read.
- R12: Immediately after reset, `empty_n` and `almost_empty_n` are low, and `full_n` and `almost_full_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wclk | input | 1 | Write clock |
| wr_en1_n | input | 1 | Active-low write enable 1 |
| wr_en2_ld | input | 1 | Second write enable or load strobe, selected at reset |
| wdata | input | 9 | Write data, or threshold byte in load steps |
| rclk | input | 1 | Read clock |
| rd_en1_n | input | 1 | Active-low read enable 1 |
| rd_en2_n | input | 1 | Active-low read enable 2 |
| out_en_n | input | 1 | Active-low output enable for rdata |
| rdata | output | 9 | Read data, high-impedance when disabled |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| almost_full_n | output | 1 | Low at or above the almost-full threshold |
| almost_empty_n | output | 1 | Low at or below the almost-empty threshold |

## Verification
The assertions assume that `wr_en2_ld` is stable across the release of reset and that the enables are never unknown. They also assume that thresholds are loaded only while the buffer is idle, because the almost-empty threshold reaches the read side without a synchronizer. The stimulus holds the mode pin for several cycles after reset is released. It loads thresholds only right after a reset, with no words stored. It drives every input on the falling edge of its own clock.

// File: rtl/fifo_dc_pkg.sv
`timescale 1ns/1ps
package fifo_dc_pkg;
  localparam int OFS_W = 16;
  localparam logic [OFS_W-1:0] OFS_DEFAULT = 16'd7;

  typedef enum logic [1:0] {
    STEP_AE_LO = 2'd0,
    STEP_AE_HI = 2'd1,
    STEP_AF_LO = 2'd2,
    STEP_AF_HI = 2'd3
  } ofs_step_e;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fifo_rst_sync.sv
`timescale 1ns/1ps
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign srst_n = stg_q[1];
endmodule

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             en1_n,
  input  logic             dual_pin,
  input  logic [WIDTH-1:0] din,
  input  logic [PW-1:0]    rptr_gray_s,
  output logic             wr_fire,
  output logic [AW-1:0]    waddr,
  output logic [PW-1:0]    wptr_gray,
  output logic             full_n,
  output logic             afull_n,
  output logic [OFS_W-1:0] ae_ofs,
  output logic             mode_dual
);
  logic [PW-1:0]    wbin_q, wbin_d, wgray_d, rbin_s, wcnt_d;
  logic             full_n_q, full_n_d, afull_n_q, afull_n_d;
  logic             load_fire;
  ofs_step_e        step_q, step_d;
  logic [OFS_W-1:0] ae_q, ae_d, af_q, af_d;
  logic             mode_q;

  // Mode is sampled from the pin for as long as the synchronized reset is held.
  always_ff @(posedge wclk) begin
    if (!wrst_n) mode_q <= dual_pin;
  end

  assign wr_fire   = !en1_n && dual_pin && full_n_q;
  assign load_fire = !mode_q && !en1_n && !dual_pin;

  always_comb begin
    wbin_d    = wbin_q + PW'(wr_fire);
    wgray_d   = wbin_d ^ (wbin_d >> 1);
    rbin_s    = PW'(gray_to_bin(32'(rptr_gray_s)));
    wcnt_d    = wbin_d - rbin_s;
    full_n_d  = !(32'(wcnt_d) == 32'(DEPTH));
    afull_n_d = !((32'(wcnt_d) + 32'(af_q)) >= 32'(DEPTH));
  end

  always_comb begin
    step_d = step_q;
    ae_d   = ae_q;
    af_d   = af_q;
    if (load_fire) begin
      unique case (step_q)
        STEP_AE_LO: ae_d[7:0]  = din[7:0];
        STEP_AE_HI: ae_d[15:8] = din[7:0];
        STEP_AF_LO: af_d[7:0]  = din[7:0];
        STEP_AF_HI: af_d[15:8] = din[7:0];
      endcase
      step_d = ofs_step_e'(step_q + 2'd1);
    end
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q    <= '0;
      wptr_gray <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
      step_q    <= STEP_AE_LO;
      ae_q      <= OFS_DEFAULT;
      af_q      <= OFS_DEFAULT;
    end else begin
      wbin_q    <= wbin_d;
      wptr_gray <= wgray_d;
      full_n_q  <= full_n_d;
      afull_n_q <= afull_n_d;
      step_q    <= step_d;
      ae_q      <= ae_d;
      af_q      <= af_d;
    end
  end

  assign waddr     = wbin_q[AW-1:0];
  assign full_n    = full_n_q;
  assign afull_n   = afull_n_q;
  assign ae_ofs    = ae_q;
  assign mode_dual = mode_q;
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             en1_n,
  input  logic             en2_n,
  input  logic [PW-1:0]    wptr_gray_s,
  input  logic [OFS_W-1:0] ae_ofs,
  output logic             rd_fire,
  output logic [AW-1:0]    raddr,
  output logic [PW-1:0]    rptr_gray,
  output logic             empty_n,
  output logic             aempty_n
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_d, wbin_s, rcnt_d;
  logic          empty_n_q, empty_n_d, aempty_n_q, aempty_n_d;

  assign rd_fire = !en1_n && !en2_n && empty_n_q;

  always_comb begin
    rbin_d     = rbin_q + PW'(rd_fire);
    rgray_d    = rbin_d ^ (rbin_d >> 1);
    wbin_s     = PW'(gray_to_bin(32'(wptr_gray_s)));
    rcnt_d     = wbin_s - rbin_d;
    empty_n_d  = (rcnt_d != '0);
    aempty_n_d = !(32'(rcnt_d) <= 32'(ae_ofs));
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q     <= '0;
      rptr_gray  <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rbin_q     <= rbin_d;
      rptr_gray  <= rgray_d;
      empty_n_q  <= empty_n_d;
      aempty_n_q <= aempty_n_d;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;
endmodule

// File: rtl/fifo_dualclk.sv
`timescale 1ns/1ps
module fifo_dualclk
  import fifo_dc_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             wr_en1_n,
  input  logic             wr_en2_ld,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             rd_en1_n,
  input  logic             rd_en2_n,
  input  logic             out_en_n,
  output wire  [WIDTH-1:0] rdata,
  output logic             full_n,
  output logic             empty_n,
  output logic             almost_full_n,
  output logic             almost_empty_n
);
  logic             wrst_n, rrst_n;
  logic             wr_fire, rd_fire, mode_dual;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s;
  logic [OFS_W-1:0] ae_ofs;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q_q;

  fifo_rst_sync u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  fifo_rst_sync u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  fifo_ptr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rptr_gray), .q(rptr_gray_s));
  fifo_ptr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wptr_gray), .q(wptr_gray_s));

  fifo_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .en1_n(wr_en1_n), .dual_pin(wr_en2_ld),
    .din(wdata), .rptr_gray_s(rptr_gray_s), .wr_fire(wr_fire), .waddr(waddr),
    .wptr_gray(wptr_gray), .full_n(full_n), .afull_n(almost_full_n),
    .ae_ofs(ae_ofs), .mode_dual(mode_dual)
  );

  fifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .wptr_gray_s(wptr_gray_s), .ae_ofs(ae_ofs), .rd_fire(rd_fire), .raddr(raddr),
    .rptr_gray(rptr_gray), .empty_n(empty_n), .aempty_n(almost_empty_n)
  );

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      q_q <= '0;
    else if (rd_fire) q_q <= mem[raddr];
  end

  assign rdata = out_en_n ? {WIDTH{1'bz}} : q_q;
endmodule

// File: rtl/fifo_dualclk_chk.sv
`timescale 1ns/1ps
module fifo_dualclk_chk #(
  parameter int PW = 10
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en1_n,
  input logic          wr_en2_ld,
  input logic          rd_en1_n,
  input logic          rd_en2_n,
  input logic          full_n,
  input logic          empty_n,
  input logic [PW-1:0] wptr_g,
  input logic [PW-1:0] rptr_g
);
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wptr_g));

  assert_write_gate_R2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en1_n || !wr_en2_ld) |=> $stable(wptr_g));

  assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr_g));

  assert_read_gate_R4: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en1_n || rd_en2_n) |=> $stable(rptr_g));

  assert_wptr_gray_R1: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wptr_g ^ $past(wptr_g)) <= 1);

  assert_rptr_gray_R1: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rptr_g ^ $past(rptr_g)) <= 1);
endmodule

bind fifo_dualclk fifo_dualclk_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
  .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
  .full_n(full_n), .empty_n(empty_n), .wptr_g(wptr_gray), .rptr_g(rptr_gray)
);

// File: tb/fifo_dualclk_tb.sv
`timescale 1ns/1ps
module fifo_dualclk_tb;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH = 512;

  logic       rst_n = 1'b0;
  logic       wclk = 1'b0, rclk = 1'b0;
  logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
  logic [8:0] wdata = '0;
  logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
  wire  [8:0] rdata;
  logic       full_n, empty_n, almost_full_n, almost_empty_n;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  fifo_dualclk #(.DEPTH(DEPTH), .WIDTH(9)) u_dut (
    .rst_n(rst_n), .wclk(wclk), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .wdata(wdata), .rclk(rclk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .out_en_n(out_en_n), .rdata(rdata), .full_n(full_n), .empty_n(empty_n),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n)
  );

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic check_flags(input int cnt, input int ae, input int af, input string req);
    logic e_empty, e_full, e_ae, e_af;
    e_empty = (cnt != 0);
    e_full  = (cnt != DEPTH);
    e_ae    = !(cnt <= ae);
    e_af    = !(cnt + af >= DEPTH);
    chk(empty_n == e_empty, {req, " empty_n"}, int'(empty_n), int'(e_empty));
    chk(full_n == e_full, {req, " full_n"}, int'(full_n), int'(e_full));
    chk(almost_empty_n == e_ae, {req, " almost_empty_n"}, int'(almost_empty_n), int'(e_ae));
    chk(almost_full_n == e_af, {req, " almost_full_n"}, int'(almost_full_n), int'(e_af));
  endtask

  task automatic do_reset(input logic pin);
    @(negedge wclk);
    rst_n = 1'b0; wr_en2_ld = pin; wr_en1_n = 1'b1;
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    repeat (4) @(negedge rclk);
    rst_n = 1'b1;
    repeat (6) @(negedge rclk);
  endtask

  task automatic write_word(input logic [8:0] d);
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b1; wdata = d;
    @(negedge wclk);
    wr_en1_n = 1'b1;
  endtask

  task automatic load_step(input logic [8:0] d);
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b0; wdata = d;
    @(negedge wclk);
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
  endtask

  task automatic read_word(output logic [8:0] v);
    @(negedge rclk);
    rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rclk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge wclk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    repeat (3) @(negedge wclk);

    // Second-enable mode
    do_reset(1'b1);
    check_flags(0, 7, 7, "R12");

    // R9 R10 R8: fill sweep with default thresholds
    for (int i = 1; i <= DEPTH; i++) begin
      write_word(pat(i));
      settle();
      check_flags(i, 7, 7, "R10");
    end
    // R3: writes while full are dropped
    write_word(9'h1AB);
    write_word(9'h0CD);
    settle();
    check_flags(DEPTH, 7, 7, "R3");
    // R1: drain in order
    for (int i = 1; i <= DEPTH; i++) begin
      read_word(v);
      chk(v == pat(i), "R1 order", int'(v), int'(pat(i)));
      settle();
      check_flags(DEPTH - i, 7, 7, "R9");
    end

    // R5: read while empty ignored
    read_word(v);
    read_word(v);
    settle();
    check_flags(0, 7, 7, "R5");
    write_word(9'h155);
    settle();
    read_word(v);
    chk(v == 9'h155, "R5 next word", int'(v), 9'h155);
    settle();

    // R2 and R6: pin low blocks writes and never loads thresholds here
    @(negedge wclk);
    wr_en1_n = 1'b0; wr_en2_ld = 1'b0; wdata = 9'h0F0;
    repeat (4) @(negedge wclk);
    wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
    settle();
    check_flags(0, 7, 7, "R2");
    for (int i = 1; i <= 9; i++) begin
      write_word(pat(i));
      settle();
      check_flags(i, 7, 7, "R6");
    end
    for (int i = 1; i <= 9; i++) begin
      read_word(v);
      chk(v == pat(i), "R2 data", int'(v), int'(pat(i)));
    end
    settle();

    // R4: one read enable high blocks the read
    write_word(9'h0AA);
    settle();
    @(negedge rclk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
    repeat (3) @(negedge rclk); rd_en1_n = 1'b1;
    settle();
    check_flags(1, 7, 7, "R4 en2 high");
    @(negedge rclk); rd_en2_n = 1'b0;
    repeat (3) @(negedge rclk); rd_en2_n = 1'b1;
    settle();
    check_flags(1, 7, 7, "R4 en1 high");
    read_word(v);
    chk(v == 9'h0AA, "R4 data", int'(v), 9'h0AA);

    // R11: output enable
    @(negedge rclk); out_en_n = 1'b1;
    @(negedge rclk);
    chk(rdata === 9'bzzzzzzzzz, "R11 hiz", int'(rdata), 0);
    out_en_n = 1'b0;
    @(negedge rclk);
    chk(rdata == 9'h0AA, "R11 drive", int'(rdata), 9'h0AA);
    settle();

    // Offset-load mode
    do_reset(1'b0);
    check_flags(0, 7, 7, "R12 load mode");
    load_step(9'h064);
    load_step(9'h000);
    load_step(9'h004);
    load_step(9'h001);
    load_step(9'h014);
    settle();
    check_flags(0, 20, 260, "R7 no array write");
    for (int i = 1; i <= DEPTH; i++) begin
      write_word(pat(i));
      settle();
      check_flags(i, 20, 260, "R7");
    end
    for (int i = 1; i <= 4; i++) begin
      read_word(v);
      chk(v == pat(i), "R1 load mode", int'(v), int'(pat(i)));
    end

    // R8: defaults return after reset
    do_reset(1'b0);
    for (int i = 1; i <= 9; i++) begin
      write_word(pat(i));
      settle();
      check_flags(i, 7, 7, "R8");
    end

    // R7: load order restarts at reset
    do_reset(1'b0);
    load_step(9'h003);
    for (int i = 1; i <= 5; i++) begin
      write_word(pat(i));
      settle();
      check_flags(i, 3, 7, "R7 restart");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule